// File: doc/BRIEF.md
# Reset Cause Recorder and Soft Reset Launcher

This block holds one 32-bit status and control word that tells software why the system last came out of reset, and lets software, or the two debounced reset buttons, ask the reset network for a new system reset. Five cause flags live in the upper bits of the word. The other 27 bits always read as zero.

The flags follow two write policies inside the same word. The power-on flag and the two button flags are cleared by writing a one. The two software flags are set by writing a one. A small saturating count records whether a reset event has already happened since power-up. When a reset event arrives with the count at zero, the word is reloaded with only the power-on flag. Any other reset event leaves the word alone. A software power-on request, or a press of the power-on button, zeroes the count, so the reset it triggers is treated as a power-on.

The block answers on a simple write-strobe register port. Read data is combinational from the address. The register word sits at offset 0xF024. The neighbouring word at 0xF020 reads zero and ignores writes.

Top module: `rst_cause_ctrl`

## Requirements
- R1: While `por_ni` is low, and after any reset event (`sys_rst_i` high at a clock edge) taken with the count at zero, the word at 0xF024 reads 0x80000000 and the count becomes non-zero.
- R2: Bits 26..0 of the word always read zero. Writing them has no effect on the word and raises no request.
- R3: Bits 31, 28 and 27 are cleared by writing a one to them. Writing a zero leaves them unchanged, and no write can set them.
- R4: Bits 30 and 29 are set by writing a one. Writing a zero leaves them unchanged. Only a reset event taken with the count at zero clears them.
- R5: A write with bit 30 set makes `rst_req_o` high for exactly the one cycle after the write edge, and zeroes the count so that the next reset event reloads 0x80000000.
- R6: A write with bit 29 set and bit 30 clear gives the same one-cycle request but keeps the count, so the next reset event keeps the word.
- R7: A reset event taken with the count non-zero leaves the word unchanged. The count saturates at one.
- R8: A one-cycle pulse on `btn_xir_i` sets bit 27, and a pulse on `btn_por_i` sets bit 28. Each gives a one-cycle request on the next cycle, and the power-on button also zeroes the count.
- R9: Reads at 0xF020 or at any address outside 0xF020..0xF027 return zero, and writes there change nothing and raise no request.
- R10: In a cycle with `sys_rst_i` high, writes and button pulses are ignored: no flag changes from them, the count is not zeroed, and `rst_req_o` stays low in the following cycle.
- R11: If a button sets a flag in the same cycle that a write clears that flag, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_ni | input | 1 | Asynchronous power-up reset, active low |
| sys_rst_i | input | 1 | System reset event from the reset network, sampled on the clock |
| bus_addr_i | input | 16 | Register port byte address |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the current address |
| btn_por_i | input | 1 | Debounced power-on button pulse |
| btn_xir_i | input | 1 | Debounced external-reset button pulse |
| rst_req_o | output | 1 | One-cycle system reset request |

## Verification
The count cannot be read through the port, so an error in it shows only at the next reset event. The bench therefore follows each request with a reset event. The word must then read either 0x80000000 or its previous value, depending on whether the count was zeroed. A flag written with the wrong policy shows on the very next read. A request pulse that is late, stretched or spurious shows on `rst_req_o` within one or two cycles of the triggering write or button pulse.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
   // Cause flags occupy the top CAUSE_W bits of the word; index 0 is the lowest.
   localparam int CAUSE_W   = 5;
   localparam int CAUSE_LSB = 27;

   localparam int IDX_BTN_XIR = 0;  // word bit 27
   localparam int IDX_BTN_POR = 1;  // word bit 28
   localparam int IDX_SW_XIR  = 2;  // word bit 29
   localparam int IDX_SW_POR  = 3;  // word bit 30
   localparam int IDX_POR     = 4;  // word bit 31

   typedef logic [CAUSE_W-1:0] cause_t;

   // Write policy per flag
   localparam cause_t CLR_ON_ONE = 5'b10011;
   localparam cause_t SET_ON_ONE = 5'b01100;
   // Value loaded on a first reset event
   localparam cause_t FIRST_LOAD = 5'b10000;
endpackage

// File: rtl/rcc_addr_decode.sv
module rcc_addr_decode #(
   parameter int          ADDR_W    = 16,
   parameter logic [15:0] BASE_ADDR = 16'hF020
) (
   input  logic [ADDR_W-1:0] addr_i,
   output logic              sel_o
);
   localparam int TAG_W = ADDR_W - 3;

   if (ADDR_W < 4) begin : g_bad_width
      $error("rcc_addr_decode: ADDR_W too small");
   end
   if (BASE_ADDR[2:0] != 3'b000) begin : g_bad_base
      $error("rcc_addr_decode: BASE_ADDR must be 8-byte aligned");
   end

   logic [TAG_W-1:0] base_tag;
   logic             unused_low_bits;

   assign base_tag        = TAG_W'(BASE_ADDR >> 3);
   assign unused_low_bits = ^addr_i[1:0];

   // Upper word of the 8-byte pair carries the register
   assign sel_o = (addr_i[ADDR_W-1:3] == base_tag) && addr_i[2];
endmodule

// File: rtl/rcc_first_tracker.sv
module rcc_first_tracker #(
   parameter int CNT_MAX = 1
) (
   input  logic clk_i,
   input  logic por_ni,
   input  logic sys_rst_i,
   input  logic clr_i,
   output logic first_o
);
   localparam int CNT_W = (CNT_MAX < 1) ? 1 : $clog2(CNT_MAX + 1);

   if (CNT_MAX < 1) begin : g_bad_max
      $error("rcc_first_tracker: CNT_MAX must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge por_ni) begin
      if (!por_ni) begin
         cnt_q <= '0;
      end else if (sys_rst_i) begin
         if (cnt_q != CNT_W'(CNT_MAX)) cnt_q <= cnt_q + 1'b1;
      end else if (clr_i) begin
         cnt_q <= '0;
      end
   end

   assign first_o = (cnt_q == '0);

   // R5 / R8: a zeroing request outside reset leaves the count at zero
   p_cnt_zeroed_r5: assert property (@(posedge clk_i) disable iff (!por_ni)
      (clr_i && !sys_rst_i) |=> first_o);
   // R7: any reset event leaves a non-zero count
   p_cnt_advance_r7: assert property (@(posedge clk_i) disable iff (!por_ni)
      sys_rst_i |=> !first_o);
endmodule

// File: rtl/rcc_cause_bits.sv
module rcc_cause_bits
   import rcc_pkg::*;
(
   input  logic   clk_i,
   input  logic   por_ni,
   input  logic   sys_rst_i,
   input  logic   first_i,
   input  logic   wr_hit_i,
   input  cause_t wbits_i,
   input  logic   btn_por_i,
   input  logic   btn_xir_i,
   output cause_t flags_o,
   output logic   cnt_clr_o,
   output logic   req_o
);
   cause_t btn_set;
   logic   req_d;

   always_comb begin
      btn_set = '0;
      btn_set[IDX_BTN_XIR] = btn_xir_i;
      btn_set[IDX_BTN_POR] = btn_por_i;
   end

   for (genvar i = 0; i < CAUSE_W; i++) begin : g_flag
      logic wr_one;
      logic nxt;

      assign wr_one = wr_hit_i && wbits_i[i];

      if (CLR_ON_ONE[i]) begin : g_clear_policy
         assign nxt = (flags_o[i] && !wr_one) || btn_set[i];
      end else begin : g_set_policy
         assign nxt = flags_o[i] || wr_one || btn_set[i];
      end

      always_ff @(posedge clk_i or negedge por_ni) begin
         if (!por_ni) begin
            flags_o[i] <= FIRST_LOAD[i];
         end else if (sys_rst_i) begin
            if (first_i) flags_o[i] <= FIRST_LOAD[i];
         end else begin
            flags_o[i] <= nxt;
         end
      end
   end

   assign cnt_clr_o = !sys_rst_i && ((wr_hit_i && wbits_i[IDX_SW_POR]) || btn_por_i);
   assign req_d     = !sys_rst_i &&
                      ((wr_hit_i && (wbits_i[IDX_SW_POR] || wbits_i[IDX_SW_XIR])) ||
                       btn_por_i || btn_xir_i);

   always_ff @(posedge clk_i or negedge por_ni) begin
      if (!por_ni) req_o <= 1'b0;
      else         req_o <= req_d;
   end

   // R1: first reset event reloads only the power-on flag
   p_first_load_r1: assert property (@(posedge clk_i) disable iff (!por_ni)
      (sys_rst_i && first_i) |=> (flags_o == FIRST_LOAD));
   // R7: later reset events keep the word
   p_later_hold_r7: assert property (@(posedge clk_i) disable iff (!por_ni)
      (sys_rst_i && !first_i) |=> $stable(flags_o));
   // R3: writing one to the power-on flag clears it
   p_por_clear_r3: assert property (@(posedge clk_i) disable iff (!por_ni)
      (wr_hit_i && wbits_i[IDX_POR] && !sys_rst_i) |=> !flags_o[IDX_POR]);
   // R4: a software flag only drops through a reset event
   p_sw_sticky_r4: assert property (@(posedge clk_i) disable iff (!por_ni)
      (flags_o[IDX_SW_POR] && !sys_rst_i) |=> flags_o[IDX_SW_POR]);
   // R8 / R11: a button pulse always leaves its flag set
   p_btn_xir_set_r8: assert property (@(posedge clk_i) disable iff (!por_ni)
      (btn_xir_i && !sys_rst_i) |=> flags_o[IDX_BTN_XIR]);
   // R10: no request follows a reset-event cycle
   p_no_req_in_rst_r10: assert property (@(posedge clk_i) disable iff (!por_ni)
      $past(sys_rst_i) |-> !req_o);
endmodule

// File: rtl/rst_cause_ctrl.sv
module rst_cause_ctrl
   import rcc_pkg::*;
#(
   parameter int          ADDR_W    = 16,
   parameter int          DATA_W    = 32,
   parameter logic [15:0] BASE_ADDR = 16'hF020,
   parameter int          CNT_MAX   = 1
) (
   input  logic              clk_i,
   input  logic              por_ni,
   input  logic              sys_rst_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic              bus_wr_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   input  logic              btn_por_i,
   input  logic              btn_xir_i,
   output logic              rst_req_o
);
   localparam int PAD_W = DATA_W - CAUSE_W - CAUSE_LSB;

   if (DATA_W != CAUSE_LSB + CAUSE_W) begin : g_bad_data
      $error("rst_cause_ctrl: DATA_W must equal 32");
   end

   logic   sel;
   logic   wr_hit;
   logic   first;
   logic   cnt_clr;
   cause_t flags;
   logic   unused_wdata_bits;

   assign unused_wdata_bits = ^bus_wdata_i[CAUSE_LSB-1:0];

   rcc_addr_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_decode (
      .addr_i (bus_addr_i),
      .sel_o  (sel)
   );

   assign wr_hit = bus_wr_i && sel;

   rcc_first_tracker #(.CNT_MAX(CNT_MAX)) u_tracker (
      .clk_i     (clk_i),
      .por_ni    (por_ni),
      .sys_rst_i (sys_rst_i),
      .clr_i     (cnt_clr),
      .first_o   (first)
   );

   rcc_cause_bits u_bits (
      .clk_i     (clk_i),
      .por_ni    (por_ni),
      .sys_rst_i (sys_rst_i),
      .first_i   (first),
      .wr_hit_i  (wr_hit),
      .wbits_i   (bus_wdata_i[CAUSE_LSB +: CAUSE_W]),
      .btn_por_i (btn_por_i),
      .btn_xir_i (btn_xir_i),
      .flags_o   (flags),
      .cnt_clr_o (cnt_clr),
      .req_o     (rst_req_o)
   );

   if (PAD_W > 0) begin : g_pad
      assign bus_rdata_o = sel ? {{PAD_W{1'b0}}, flags, {CAUSE_LSB{1'b0}}} : '0;
   end else begin : g_nopad
      assign bus_rdata_o = sel ? {flags, {CAUSE_LSB{1'b0}}} : '0;
   end

   // R5: a software power-on write requests exactly one cycle later
   p_swpor_req_r5: assert property (@(posedge clk_i) disable iff (!por_ni)
      (wr_hit && bus_wdata_i[30] && !sys_rst_i) |=> rst_req_o);
endmodule

// File: tb/rst_cause_ctrl_tb_top.sv
module rst_cause_ctrl_tb_top;
   logic        clk_i = 1'b0;
   logic        por_ni = 1'b0;
   logic        sys_rst_i = 1'b0;
   logic [15:0] bus_addr_i = 16'h0000;
   logic        bus_wr_i = 1'b0;
   logic [31:0] bus_wdata_i = '0;
   logic [31:0] bus_rdata_o;
   logic        btn_por_i = 1'b0;
   logic        btn_xir_i = 1'b0;
   logic        rst_req_o;

   int n_chk = 0;
   int n_bad = 0;
   int cycles = 0;
   bit done = 0;

   localparam logic [15:0] A_REG  = 16'hF024;
   localparam logic [15:0] A_PAIR = 16'hF020;

   always #2 clk_i = ~clk_i;  // 250 MHz

   rst_cause_ctrl dut_i (
      .clk_i, .por_ni, .sys_rst_i, .bus_addr_i, .bus_wr_i, .bus_wdata_i,
      .bus_rdata_o, .btn_por_i, .btn_xir_i, .rst_req_o
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %08h expected %08h", tag, got, exp);
      end
   endtask

   task automatic rd(input logic [15:0] a, output logic [31:0] d);
      bus_addr_i = a;
      #1;
      d = bus_rdata_o;
   endtask

   task automatic chk_word(input string tag, input logic [31:0] exp);
      logic [31:0] d;
      rd(A_REG, d);
      chk(tag, d, exp);
   endtask

   // One write; checks the request in the following cycle and its end
   task automatic wr(input string tag, input logic [15:0] a, input logic [31:0] d,
                     input logic exp_req);
      @(negedge clk_i);
      bus_addr_i = a; bus_wdata_i = d; bus_wr_i = 1'b1;
      @(negedge clk_i);
      bus_wr_i = 1'b0; bus_wdata_i = '0;
      chk({tag, " req"}, 32'(rst_req_o), 32'(exp_req));
      @(negedge clk_i);
      chk({tag, " req end"}, 32'(rst_req_o), 32'h0);
   endtask

   task automatic sysrst(input string tag);
      @(negedge clk_i);
      sys_rst_i = 1'b1;
      @(negedge clk_i);
      sys_rst_i = 1'b0;
      chk({tag, " no req"}, 32'(rst_req_o), 32'h0);
   endtask

   task automatic button(input string tag, input bit por);
      @(negedge clk_i);
      if (por) btn_por_i = 1'b1; else btn_xir_i = 1'b1;
      @(negedge clk_i);
      btn_por_i = 1'b0; btn_xir_i = 1'b0;
      chk({tag, " req"}, 32'(rst_req_o), 32'h1);
      @(negedge clk_i);
      chk({tag, " req end"}, 32'(rst_req_o), 32'h0);
   endtask

   task automatic t_power_up;
      logic [31:0] d;
      repeat (3) @(negedge clk_i);
      chk_word("R1 word during power-up reset", 32'h8000_0000);
      chk("R1 no request in reset", 32'(rst_req_o), 32'h0);
      por_ni = 1'b1;
      @(negedge clk_i);
      sysrst("R1 first reset event");
      chk_word("R1 word after first event", 32'h8000_0000);
      rd(A_PAIR, d);
      chk("R9 pair word reads zero", d, 32'h0);
   endtask

   task automatic t_clear_policy;
      wr("R3 clear power-on flag", A_REG, 32'h8000_0000, 1'b0);
      chk_word("R3 power-on flag cleared", 32'h0);
      wr("R2 reserved bits write", A_REG, 32'h07FF_FFFF, 1'b0);
      chk_word("R2 reserved bits stay zero", 32'h0);
      wr("R3 button flags not settable", A_REG, 32'h1800_0000, 1'b0);
      chk_word("R3 button flags stay clear", 32'h0);
   endtask

   task automatic t_soft_xir;
      wr("R6 soft external reset write", A_REG, 32'h2000_0000, 1'b1);
      chk_word("R6 flag 29 set", 32'h2000_0000);
      wr("R4 write zero", A_REG, 32'h0, 1'b0);
      chk_word("R4 flag 29 kept on zero write", 32'h2000_0000);
      sysrst("R6 reset after soft external");
      chk_word("R6 count kept, word kept", 32'h2000_0000);
   endtask

   task automatic t_soft_por;
      wr("R5 soft power-on write", A_REG, 32'h4000_0000, 1'b1);
      chk_word("R5 flag 30 set", 32'h6000_0000);
      sysrst("R5 reset after soft power-on");
      chk_word("R5 reload to power-on only", 32'h8000_0000);
      wr("R7 soft external write", A_REG, 32'h2000_0000, 1'b1);
      sysrst("R7 later reset");
      chk_word("R7 later reset keeps word", 32'hA000_0000);
      sysrst("R7 saturated count reset");
      chk_word("R7 count saturated, word kept", 32'hA000_0000);
   endtask

   task automatic t_other_addresses;
      logic [31:0] d;
      wr("R9 write pair word", A_PAIR, 32'hC000_0000, 1'b0);
      chk_word("R9 pair write ignored", 32'hA000_0000);
      wr("R9 write far address", 16'h1004, 32'hE000_0000, 1'b0);
      chk_word("R9 far write ignored", 32'hA000_0000);
      rd(16'h1004, d);
      chk("R9 far read zero", d, 32'h0);
   endtask

   task automatic t_buttons;
      button("R8 external button", 1'b0);
      chk_word("R8 flag 27 set", 32'hA800_0000);
      // same-cycle clear and button set of flag 27
      @(negedge clk_i);
      bus_addr_i = A_REG; bus_wdata_i = 32'h0800_0000; bus_wr_i = 1'b1; btn_xir_i = 1'b1;
      @(negedge clk_i);
      bus_wr_i = 1'b0; bus_wdata_i = '0; btn_xir_i = 1'b0;
      chk("R11 request from button", 32'(rst_req_o), 32'h1);
      chk_word("R11 button wins over clear", 32'hA800_0000);
      wr("R3 clear flag 27", A_REG, 32'h0800_0000, 1'b0);
      chk_word("R3 flag 27 cleared", 32'hA000_0000);
      button("R8 power-on button", 1'b1);
      chk_word("R8 flag 28 set", 32'hB000_0000);
      sysrst("R8 reset after power-on button");
      chk_word("R8 button zeroed count", 32'h8000_0000);
   endtask

   task automatic t_during_reset;
      wr("R10 setup write", A_REG, 32'h2000_0000, 1'b1);
      chk_word("R10 setup word", 32'hA000_0000);
      @(negedge clk_i);
      sys_rst_i = 1'b1; bus_addr_i = A_REG; bus_wdata_i = 32'hC800_0000;
      bus_wr_i = 1'b1; btn_xir_i = 1'b1; btn_por_i = 1'b1;
      @(negedge clk_i);
      sys_rst_i = 1'b0; bus_wr_i = 1'b0; bus_wdata_i = '0;
      btn_xir_i = 1'b0; btn_por_i = 1'b0;
      chk("R10 no request after reset cycle", 32'(rst_req_o), 32'h0);
      chk_word("R10 writes and buttons ignored", 32'hA000_0000);
      sysrst("R10 count not zeroed");
      chk_word("R10 word kept on next reset", 32'hA000_0000);
   endtask

   always @(posedge clk_i) begin
      cycles <= cycles + 1;
      if (cycles > 20000 && !done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got %0d cycles expected fewer than 20000", cycles);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      t_power_up();
      t_clear_policy();
      t_soft_xir();
      t_soft_por();
      t_other_addresses();
      t_buttons();
      t_during_reset();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule